// File: doc/BRIEF.md
# Parallel Flash Write Strobe Sequencer

This block sits between a synchronous host and an asynchronous parallel NOR-style flash device. It carries out single-word write cycles. The host offers an address and a data word on a valid/ready handshake. The sequencer then drives chip enable, write enable, the address bus and the data bus so that every analog minimum of the flash is met. It meets them by counting clock cycles. Every interval is the ceiling of the nanosecond minimum divided by the clock period parameter.

Chip enable stays low for the whole cycle, and write enable is the strobe that starts and ends the write. After the strobe rises, a watcher waits for the device's busy pin to fall and then to rise again. If the pin never falls inside the allowed window, the write is reported as failed. The program-enable output stays high until the cycle is resolved.

The ready signal is held low in four cases:
- while the density-dependent reset recovery is still running;
- during a write;
- while the busy wait is pending;
- until the write-to-read recovery interval has elapsed.

A read controller sharing the bus can therefore use ready as its go signal.

Top module: `fwseq_top`

## Requirements
- R1: After reset, every output is idle: ready low, chip enable, write enable and program enable inactive, data bus not driven. Ready stays low for exactly ceil(T/CLK_NS) clock edges after reset release, where T is 150 ns for a 32 Mbit density, 180 ns for 64 Mbit and 210 ns for 128 Mbit. The first write-enable fall therefore comes at least T after release.
- R2: Each write-enable low pulse lasts at least ceil(60/CLK_NS) cycles, and at least 60 ns.
- R3: Address and data do not change while write enable is low. They are stable at least 55 ns (address) and 50 ns (data) before write enable rises. They are held, with chip enable still low, for one cycle after the rise. The values on the pins are those of the accepted request.
- R4: Chip enable is low whenever write enable is low, and it falls no later than write enable.
- R5: Write enable stays high for at least 30 ns between two successive low pulses.
- R6: Ready is low from the accepting edge until two conditions hold: the busy wait has resolved, and at least ceil(35/CLK_NS) cycles (35 ns or more) have passed since write enable rose.
- R7: After write enable rises, busy_n is watched for ceil(500/CLK_NS) cycles. If it goes low in that window, the block waits for it to return high and then completes with fail=0. If it does not, the block completes with fail=1.
- R8: Program enable rises when a request is accepted. It is held high through the strobe and until busy_n has returned high or the watch has timed out.
- R9: A request presented while ready is low is ignored. It produces no write pulse, and the address of the write in progress is unchanged.
- R10: Each accepted request produces exactly one single-cycle done pulse, and its fail flag is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS nanoseconds |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Sequencer can accept a write |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | DATA_W | Word to write |
| wr_done | output | 1 | One-cycle completion pulse |
| wr_fail | output | 1 | Busy pin never fell; valid with wr_done |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq | output | DATA_W | Flash data bus, output value |
| fl_dq_oe | output | 1 | Drive enable for fl_dq |
| fl_vpen | output | 1 | Program-enable supply control |
| fl_busy_n | input | 1 | Flash status pin, low while busy |

## Verification
The hardest state to reach is a second request arriving while the busy watcher is still waiting. From outside, this looks like an ordinary idle bus with ready low. The bench gets there with a busy-pin responder that holds the pin low for thirty cycles. It raises valid with a different address during that window and then withdraws it before ready returns. Afterwards it confirms that no extra strobe appeared and that the captured address is unchanged. The timeout path is reached by a table entry that tells the responder never to pull the pin low.

// File: rtl/fwseq_pkg.sv
`timescale 1ns/1ps
package fwseq_pkg;

    localparam int WP_MIN_NS    = 60;   // strobe low
    localparam int WPH_MIN_NS   = 30;   // strobe high between pulses
    localparam int DSU_MIN_NS   = 50;   // data setup to rising strobe
    localparam int ASU_MIN_NS   = 55;   // address setup to rising strobe
    localparam int RDREC_MIN_NS = 35;   // rising strobe to next read
    localparam int BUSY_MAX_NS  = 500;  // rising strobe to busy low

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // recovery from reset depends on array density
    function automatic int rst_recov_ns(input int mbit);
        if (mbit <= 32)      return 150;
        else if (mbit <= 64) return 180;
        else                 return 210;
    endfunction

    typedef enum logic [2:0] {
        ST_RECOV,
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_WAIT
    } wr_state_e;

    typedef enum logic [1:0] {
        BW_IDLE,
        BW_LOW,
        BW_HIGH
    } bw_state_e;

endpackage

// File: rtl/fwseq_busy_watch.sv
`timescale 1ns/1ps
module fwseq_busy_watch
    import fwseq_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_n_i,
    output logic done_o,
    output logic fail_o
);
    localparam int LIMIT = ceil_div(BUSY_MAX_NS, CLK_NS);
    localparam int TW    = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIMIT_C = TW'(LIMIT);

    typedef struct packed {
        bw_state_e      st;
        logic [TW-1:0]  tmr;
        logic           done;
        logic           fail;
    } bw_regs_t;

    bw_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.fail = 1'b0;
        case (q.st)
            BW_IDLE: begin
                if (start_i) begin
                    d.tmr = TW'(1);
                    d.st  = busy_n_i ? BW_LOW : BW_HIGH;
                end
            end
            BW_LOW: begin
                if (!busy_n_i) begin
                    d.st = BW_HIGH;
                end else if (q.tmr >= LIMIT_C) begin
                    d.st   = BW_IDLE;
                    d.done = 1'b1;
                    d.fail = 1'b1;
                end else begin
                    d.tmr = q.tmr + TW'(1);
                end
            end
            BW_HIGH: begin
                if (busy_n_i) begin
                    d.st   = BW_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = BW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: BW_IDLE, tmr: '0, done: 1'b0, fail: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign fail_o = q.fail;

    p_fail_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);
    p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BW_LOW) |-> (q.tmr <= LIMIT_C));

endmodule

// File: rtl/fwseq_ctrl.sv
`timescale 1ns/1ps
module fwseq_ctrl
    import fwseq_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int DENSITY_MBIT = 64,
    parameter int ADDR_W       = 22,
    parameter int DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic              bw_done,
    input  logic              bw_fail,
    output logic              bw_start,
    output logic              wr_done,
    output logic              wr_fail,
    output logic              ce_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe,
    output logic              vpen
);
    localparam int RST_CYC = ceil_div(rst_recov_ns(DENSITY_MBIT), CLK_NS);
    localparam int WP_CYC  = ceil_div(WP_MIN_NS, CLK_NS);
    localparam int WPH_CYC = ceil_div(WPH_MIN_NS, CLK_NS);
    localparam int SU_CYC  = ceil_div(imax(ASU_MIN_NS, DSU_MIN_NS), CLK_NS);
    localparam int REC_CYC = ceil_div(RDREC_MIN_NS, CLK_NS);
    // one setup cycle precedes the low phase, so the low phase covers the rest
    localparam int LOW_CYC = imax(WP_CYC, SU_CYC - 1);
    localparam int GAP_CYC = imax(WPH_CYC, REC_CYC);
    localparam int CW      = $clog2(imax(RST_CYC, imax(LOW_CYC, GAP_CYC)) + 1);

    typedef struct packed {
        wr_state_e          st;
        logic [CW-1:0]      cnt;
        logic [CW-1:0]      gap;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic               ce_n;
        logic               we_n;
        logic               oe;
        logic               vpen;
        logic               start;
        logic               done;
        logic               fail;
    } ctl_regs_t;

    ctl_regs_t q, d;

    assign req_ready = (q.st == ST_IDLE) && (q.gap == '0);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.done  = 1'b0;
        if (q.gap != '0) d.gap = q.gap - CW'(1);
        case (q.st)
            ST_RECOV: begin
                if (q.cnt == '0) d.st = ST_IDLE;
                else             d.cnt = q.cnt - CW'(1);
            end
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    d.st   = ST_SETUP;
                    d.addr = req_addr;
                    d.data = req_data;
                    d.ce_n = 1'b0;
                    d.oe   = 1'b1;
                    d.vpen = 1'b1;
                    d.fail = 1'b0;
                end
            end
            ST_SETUP: begin
                d.st   = ST_PULSE;
                d.we_n = 1'b0;
                d.cnt  = CW'(LOW_CYC - 1);
            end
            ST_PULSE: begin
                if (q.cnt == '0) begin
                    d.st    = ST_HOLD;
                    d.we_n  = 1'b1;
                    d.gap   = CW'(GAP_CYC);
                    d.start = 1'b1;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            ST_HOLD: begin
                d.st   = ST_WAIT;
                d.ce_n = 1'b1;
                d.oe   = 1'b0;
            end
            ST_WAIT: begin
                if (bw_done) begin
                    d.st   = ST_IDLE;
                    d.vpen = 1'b0;
                    d.done = 1'b1;
                    d.fail = bw_fail;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RECOV, cnt: CW'(RST_CYC - 1), gap: '0,
                   addr: '0, data: '0, ce_n: 1'b1, we_n: 1'b1, oe: 1'b0,
                   vpen: 1'b0, start: 1'b0, done: 1'b0, fail: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bw_start = q.start;
    assign wr_done  = q.done;
    assign wr_fail  = q.fail;
    assign ce_n     = q.ce_n;
    assign we_n     = q.we_n;
    assign addr     = q.addr;
    assign dq       = q.data;
    assign dq_oe    = q.oe;
    assign vpen     = q.vpen;

    // observation counters for the interval properties
    logic [15:0] since_rst_q, low_run_q, high_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
            low_run_q   <= '0;
            high_run_q  <= '1;
        end else begin
            if (since_rst_q != '1) since_rst_q <= since_rst_q + 16'd1;
            low_run_q <= we_n ? 16'd0 : low_run_q + 16'd1;
            if (!we_n)                high_run_q <= '0;
            else if (high_run_q != '1) high_run_q <= high_run_q + 16'd1;
        end
    end

    p_ready_after_recovery_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (since_rst_q >= 16'(RST_CYC)));
    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (low_run_q >= 16'(WP_CYC)));
    p_bus_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> ($stable(addr) && $stable(dq) && dq_oe));
    p_ce_covers_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);
    p_high_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> (high_run_q >= 16'(WPH_CYC)));
    p_no_ready_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n || q.st == ST_WAIT) |-> !req_ready);
    p_vpen_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> vpen);
    p_single_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

endmodule

// File: rtl/fwseq_top.sv
`timescale 1ns/1ps
module fwseq_top #(
    parameter int CLK_NS       = 10,
    parameter int DENSITY_MBIT = 64,
    parameter int ADDR_W       = 22,
    parameter int DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              wr_done,
    output logic              wr_fail,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq,
    output logic              fl_dq_oe,
    output logic              fl_vpen,
    input  logic              fl_busy_n
);
    logic bw_start, bw_done, bw_fail;

    fwseq_ctrl #(
        .CLK_NS(CLK_NS), .DENSITY_MBIT(DENSITY_MBIT),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_ready(req_ready),
        .bw_done(bw_done), .bw_fail(bw_fail), .bw_start(bw_start),
        .wr_done(wr_done), .wr_fail(wr_fail),
        .ce_n(fl_ce_n), .we_n(fl_we_n), .addr(fl_addr), .dq(fl_dq),
        .dq_oe(fl_dq_oe), .vpen(fl_vpen)
    );

    fwseq_busy_watch #(.CLK_NS(CLK_NS)) u_busy (
        .clk(clk), .rst_n(rst_n), .start_i(bw_start), .busy_n_i(fl_busy_n),
        .done_o(bw_done), .fail_o(bw_fail)
    );

endmodule

// File: tb/fwseq_top_bench.sv
`timescale 1ns/1ps
module fwseq_top_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NV = 6;

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  dly;   // 255: pin never goes low
        logic [7:0]  len;
        logic        fail;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{addr: 16'h0001, data: 16'hA5A5, dly: 8'd2,   len: 8'd5,  fail: 1'b0},
        '{addr: 16'hFFFF, data: 16'h0000, dly: 8'd10,  len: 8'd20, fail: 1'b0},
        '{addr: 16'h8000, data: 16'hFFFF, dly: 8'd40,  len: 8'd3,  fail: 1'b0},
        '{addr: 16'h0F0F, data: 16'h1234, dly: 8'd255, len: 8'd0,  fail: 1'b1},
        '{addr: 16'h7FFE, data: 16'h8001, dly: 8'd1,   len: 8'd60, fail: 1'b0},
        '{addr: 16'h2222, data: 16'hC3C3, dly: 8'd255, len: 8'd0,  fail: 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic fl_busy_n = 1'b1;
    logic req_ready, wr_done, wr_fail, fl_ce_n, fl_we_n, fl_dq_oe, fl_vpen;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq;
    logic rdy32, rdy128;
    logic u32_done, u32_fail, u32_ce, u32_we, u32_oe, u32_vp;
    logic u128_done, u128_fail, u128_ce, u128_we, u128_oe, u128_vp;
    logic [AW-1:0] u32_a, u128_a;
    logic [DW-1:0] u32_d, u128_d;

    always #5 clk = ~clk;

    fwseq_top #(.CLK_NS(10), .DENSITY_MBIT(64), .ADDR_W(AW), .DATA_W(DW)) u_fwseq_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .wr_done(wr_done), .wr_fail(wr_fail),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq(fl_dq),
        .fl_dq_oe(fl_dq_oe), .fl_vpen(fl_vpen), .fl_busy_n(fl_busy_n));

    fwseq_top #(.CLK_NS(10), .DENSITY_MBIT(32), .ADDR_W(AW), .DATA_W(DW)) u_fwseq_top_d32 (
        .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(rdy32),
        .req_addr('0), .req_data('0), .wr_done(u32_done), .wr_fail(u32_fail),
        .fl_ce_n(u32_ce), .fl_we_n(u32_we), .fl_addr(u32_a), .fl_dq(u32_d),
        .fl_dq_oe(u32_oe), .fl_vpen(u32_vp), .fl_busy_n(1'b1));

    fwseq_top #(.CLK_NS(10), .DENSITY_MBIT(128), .ADDR_W(AW), .DATA_W(DW)) u_fwseq_top_d128 (
        .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_ready(rdy128),
        .req_addr('0), .req_data('0), .wr_done(u128_done), .wr_fail(u128_fail),
        .fl_ce_n(u128_ce), .fl_we_n(u128_we), .fl_addr(u128_a), .fl_dq(u128_d),
        .fl_dq_oe(u128_oe), .fl_vpen(u128_vp), .fl_busy_n(1'b1));

    int n_tests = 0;
    int n_fail  = 0;
    bit armed   = 1'b0;
    bit finished = 1'b0;
    int n_fall = 0;
    int n_done = 0;
    int n_acc  = 0;
    int m_dly  = 0;
    int m_len  = 0;
    bit busy_done = 1'b1;
    realtime t_rel, t_fall, t_rise, t_addr, t_data;
    logic [AW-1:0] cap_addr = '0;
    logic [DW-1:0] cap_data = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // pin edge timing monitors
    always @(fl_addr) t_addr = $realtime;
    always @(fl_dq)   t_data = $realtime;

    always @(negedge fl_we_n) if (armed) begin
        chk(fl_ce_n == 1'b0, "R4", "chip enable low at strobe fall", fl_ce_n, 0);
        if (n_fall == 0)
            chk($realtime - t_rel >= 180.0, "R1", "reset release to first strobe ns",
                longint'($realtime - t_rel), 180);
        else
            chk($realtime - t_rise >= 30.0, "R5", "strobe high gap ns",
                longint'($realtime - t_rise), 30);
        t_fall = $realtime;
        n_fall++;
    end

    always @(posedge fl_we_n) if (armed) begin
        chk($realtime - t_fall >= 60.0, "R2", "strobe low width ns",
            longint'($realtime - t_fall), 60);
        chk($realtime - t_addr >= 55.0, "R3", "address setup ns",
            longint'($realtime - t_addr), 55);
        chk($realtime - t_data >= 50.0, "R3", "data setup ns",
            longint'($realtime - t_data), 50);
        cap_addr = fl_addr;
        cap_data = fl_dq;
        t_rise = $realtime;
    end

    always @(posedge fl_ce_n) if (armed) begin
        chk((fl_addr == cap_addr) && ($realtime - t_rise >= 10.0), "R3",
            "address held one cycle after strobe rise", fl_addr, cap_addr);
    end

    always @(negedge fl_vpen) if (armed) begin
        chk(fl_busy_n == 1'b1, "R8", "busy pin high when program enable drops",
            fl_busy_n, 1);
    end

    always @(negedge clk) if (armed && wr_done) n_done++;

    // flash status pin responder
    always begin
        @(posedge fl_we_n);
        if (armed) begin
            busy_done = 1'b0;
            if (m_dly != 255) begin
                repeat (m_dly) @(negedge clk);
                fl_busy_n = 1'b0;
                repeat (m_len) @(negedge clk);
                fl_busy_n = 1'b1;
            end
            busy_done = 1'b1;
        end
    end

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] dv);
        wait_ready();
        req_addr  = a;
        req_data  = dv;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_acc++;
        chk(req_ready == 1'b0, "R6", "ready low after accept", req_ready, 0);
        chk(fl_vpen == 1'b1, "R8", "program enable high after accept", fl_vpen, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int r64 = -1, r32 = -1, r128 = -1, k = 0;
        repeat (3) @(negedge clk);
        // reset state
        chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
        chk(fl_we_n && fl_ce_n, "R1", "strobes inactive in reset", {fl_ce_n, fl_we_n}, 3);
        chk(!fl_vpen && !fl_dq_oe, "R1", "vpen and bus drive off in reset",
            {fl_vpen, fl_dq_oe}, 0);
        rst_n = 1'b1;
        t_rel = $realtime;
        t_fall = $realtime;
        t_rise = $realtime;
        armed = 1'b1;
        // recovery length per density
        while ((r64 < 0 || r32 < 0 || r128 < 0) && k < 60) begin
            @(negedge clk);
            k++;
            if (r64 < 0 && req_ready) r64 = k;
            if (r32 < 0 && rdy32)     r32 = k;
            if (r128 < 0 && rdy128)   r128 = k;
        end
        chk(r32 == 15, "R1", "32 Mbit recovery edges", r32, 15);
        chk(r64 == 18, "R1", "64 Mbit recovery edges", r64, 18);
        chk(r128 == 21, "R1", "128 Mbit recovery edges", r128, 21);

        // table of writes
        for (int i = 0; i < NV; i++) begin
            m_dly = int'(VECS[i].dly);
            m_len = int'(VECS[i].len);
            issue(VECS[i].addr, VECS[i].data);
            while (!wr_done) @(negedge clk);
            chk(wr_fail == VECS[i].fail, "R7", "fail flag with done", wr_fail, VECS[i].fail);
            chk(cap_addr == VECS[i].addr, "R3", "address at strobe rise", cap_addr, VECS[i].addr);
            chk(cap_data == VECS[i].data, "R3", "data at strobe rise", cap_data, VECS[i].data);
            @(negedge clk);
            chk(wr_done == 1'b0, "R10", "done lasts one cycle", wr_done, 0);
            wait_ready();
            chk($realtime - t_rise >= 35.0, "R6", "strobe rise to ready ns",
                longint'($realtime - t_rise), 35);
            chk(busy_done && fl_busy_n, "R6", "busy resolved before ready",
                {busy_done, fl_busy_n}, 3);
        end

        // request offered during the busy wait is ignored
        begin
            int falls_before;
            m_dly = 2;
            m_len = 30;
            falls_before = n_fall;
            issue(16'h1357, 16'h2468);
            while (!fl_ce_n || fl_busy_n) @(negedge clk);
            req_addr  = 16'h9999;
            req_data  = 16'h6666;
            req_valid = 1'b1;
            repeat (10) @(negedge clk);
            req_valid = 1'b0;
            while (!wr_done) @(negedge clk);
            chk(wr_fail == 1'b0, "R7", "busy seen low, no fail", wr_fail, 0);
            wait_ready();
            repeat (5) @(negedge clk);
            chk(n_fall == falls_before + 1, "R9", "strobes for one accepted write",
                n_fall, falls_before + 1);
            chk(cap_addr == 16'h1357, "R9", "address unaffected by ignored request",
                cap_addr, 16'h1357);
            chk(req_ready == 1'b1 && fl_ce_n, "R9", "nothing pending afterwards",
                {req_ready, fl_ce_n}, 3);
        end

        chk(n_done == n_acc, "R10", "done pulses per accepted write", n_done, n_acc);
        summary();
    end

endmodule